// File: doc/BRIEF.md
# Single-Drop One-Wire Slave Interface

This block is the slave end of a one-wire bus that carries exactly one device. It watches the open-drain data line through a synchroniser and times every low period with a cycle counter. All durations are scaled from a ticks-per-microsecond parameter. A low period long enough to be a bus reset makes the block answer with a presence pulse. Any shorter low period is a time slot that carries one bit.

There is only one slave on the bus, so no addressing phase exists. The core's function command follows the presence pulse directly. Every bus reset cancels whatever transaction was in progress.

Bits are carried least significant first. In the receive direction, the block assembles eight write slots into a byte and presents it with a one-cycle valid flag. In the transmit direction, the core offers a byte through a valid/ready handshake. The block then answers the next eight slots as read slots: for a 0 bit it pulls the line low, and for a 1 bit it leaves the line released.

The block does not drive the pad. It only provides a registered pull-low enable for the pad driver to use.

Top module: `onewire_slave_if`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `dq_pull_o`, `rx_valid_o` and `bus_reset_o` are 0 and `tx_ready_o` is 1.
- R2: If the synchronised line stays low for RESET_US microseconds after a falling edge, `bus_reset_o` pulses high for exactly one cycle. This happens RESET_US×TICKS_PER_US + 2 clock edges after the first edge that samples the line low. `dq_pull_o` is 0 during that pulse.
- R3: After a bus reset, once the line is seen high again, the block waits PD_WAIT_US microseconds. It then holds `dq_pull_o` high for PD_LOW_US microseconds. With the defaults this is 30 µs and 120 µs.
- R4: When no transmit byte is held, a slot is a write slot. The line is sampled SAMPLE_US (30 µs) after the detected falling edge, with high meaning 1 and low meaning 0. The first slot gives bit 0 of the byte. When the eighth slot ends, `rx_byte_o` is updated and `rx_valid_o` pulses for one cycle.
- R5: A byte is taken from `tx_byte_i` on a clock edge where `tx_valid_i` and `tx_ready_o` are both 1. `tx_ready_o` then stays 0 until eight read slots have ended. In each read slot, starting from bit 0, a 0 bit raises `dq_pull_o` for SAMPLE_US from the cycle after the falling edge is detected. A 1 bit leaves the line released.
- R6: A bus reset discards any partly received bits, so the next eight write slots form a whole new byte. It also drops a held transmit byte, so `tx_ready_o` is 1 on the cycle after `bus_reset_o`.
- R7: A low period that ends before the reset threshold, even one far longer than a normal slot, is a single 0 bit. It produces no `bus_reset_o` and no presence pulse.
- R8: `dq_pull_o` is high only inside a presence window (R3) or a read-0 window (R5). It never stays high for more cycles than the longer of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| dq_i | input | 1 | Level seen on the open-drain data line |
| dq_pull_o | output | 1 | 1 = pad driver pulls the line low |
| rx_byte_o | output | BYTE_W | Last byte assembled from write slots |
| rx_valid_o | output | 1 | One-cycle strobe when `rx_byte_o` is new |
| tx_byte_i | input | BYTE_W | Byte to be sent in read slots |
| tx_valid_i | input | 1 | Core offers `tx_byte_i` |
| tx_ready_o | output | 1 | No byte held; an offer is accepted on this edge |
| bus_reset_o | output | 1 | One-cycle strobe on each detected bus reset |

## Verification
The assertions assume a well-behaved master. It leaves the line high for at least two clocks between slots. It does not pull the line low during the wait and presence phases that follow a reset. It does not start a slot in the same cycle as the core hands over a transmit byte.

The stimulus keeps to these assumptions by building every slot from a fixed shape: a 3 µs or 70 µs master low within a 75 µs slot, a read strobe at 13 µs, and resets held for 500 µs. Transmit bytes are offered only between slots. The long low of R7 stops 80 µs short of the reset threshold, so it stays clearly on one side of the boundary.

// File: rtl/ow_slave_pkg.sv
package ow_slave_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_TAIL,
    ST_RST_HI,
    ST_PD_WAIT,
    ST_PD_DRV,
    ST_PD_REL
  } ow_state_e;
endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dq_i,
  output logic line_o,
  output logic fell_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], dq_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign line_o = sync_q[STAGES-1];
  assign fell_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
  import ow_slave_pkg::*;
#(
  parameter int SLOT_PT   = 3000,
  parameter int RESET_T   = 48000,
  parameter int PD_WAIT_T = 3000,
  parameter int PD_LOW_T  = 12000
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic fell_i,
  input  logic tx_active_i,
  input  logic tx_bit_i,
  output logic pull_o,
  output logic bit_evt_o,
  output logic bit_val_o,
  output logic slot_rd_o,
  output logic abort_o,
  output logic bus_reset_o
);
  localparam int CNT_W = $clog2(RESET_T + 1);
  localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_PT - 1);
  localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(RESET_T - 1);
  localparam logic [CNT_W-1:0] PDW_LAST  = CNT_W'(PD_WAIT_T - 1);
  localparam logic [CNT_W-1:0] PDL_LAST  = CNT_W'(PD_LOW_T - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;

  ow_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      pull_o      <= 1'b0;
      bit_evt_o   <= 1'b0;
      bit_val_o   <= 1'b0;
      slot_rd_o   <= 1'b0;
      abort_o     <= 1'b0;
      bus_reset_o <= 1'b0;
    end else begin
      bit_evt_o   <= 1'b0;
      abort_o     <= 1'b0;
      bus_reset_o <= 1'b0;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (fell_i) begin
            state_q   <= ST_SLOT;
            cnt_q     <= '0;
            slot_rd_o <= tx_active_i;
            pull_o    <= tx_active_i & ~tx_bit_i;
          end
        end
        ST_SLOT: begin
          if (cnt_q == SLOT_LAST) begin
            bit_val_o <= line_i;
            pull_o    <= 1'b0;
            state_q   <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (line_i) begin
            bit_evt_o <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (cnt_q == RST_LAST) begin
            bus_reset_o <= 1'b1;
            abort_o     <= 1'b1;
            state_q     <= ST_RST_HI;
          end
        end
        ST_RST_HI: begin
          if (line_i) begin
            cnt_q   <= '0;
            state_q <= ST_PD_WAIT;
          end
        end
        ST_PD_WAIT: begin
          if (cnt_q == PDW_LAST) begin
            cnt_q   <= '0;
            pull_o  <= 1'b1;
            state_q <= ST_PD_DRV;
          end
        end
        ST_PD_DRV: begin
          if (cnt_q == PDL_LAST) begin
            pull_o  <= 1'b0;
            state_q <= ST_PD_REL;
          end
        end
        ST_PD_REL: begin
          if (line_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ow_byte_shifter.sv
module ow_byte_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_evt_i,
  input  logic              bit_val_i,
  input  logic              slot_rd_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              tx_valid_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              tx_active_o,
  output logic              tx_bit_o
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] rx_sr_q;
  logic [BIT_W-1:0]  rx_cnt_q;
  logic [DATA_W-1:0] tx_sr_q;
  logic [BIT_W-1:0]  tx_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sr_q    <= '0;
      rx_cnt_q   <= '0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (abort_i) begin
        rx_cnt_q <= '0;
      end else if (bit_evt_i && !slot_rd_i) begin
        rx_sr_q <= {bit_val_i, rx_sr_q[DATA_W-1:1]};
        if (rx_cnt_q == LAST_BIT) begin
          rx_cnt_q   <= '0;
          rx_byte_o  <= {bit_val_i, rx_sr_q[DATA_W-1:1]};
          rx_valid_o <= 1'b1;
        end else begin
          rx_cnt_q <= rx_cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr_q     <= '0;
      tx_cnt_q    <= '0;
      tx_active_o <= 1'b0;
    end else if (abort_i) begin
      tx_active_o <= 1'b0;
    end else if (!tx_active_o) begin
      if (tx_valid_i) begin
        tx_sr_q     <= tx_byte_i;
        tx_cnt_q    <= '0;
        tx_active_o <= 1'b1;
      end
    end else if (bit_evt_i && slot_rd_i) begin
      tx_sr_q <= {1'b1, tx_sr_q[DATA_W-1:1]};
      if (tx_cnt_q == LAST_BIT) tx_active_o <= 1'b0;
      else                      tx_cnt_q    <= tx_cnt_q + 1'b1;
    end
  end

  assign tx_bit_o = tx_sr_q[0];
endmodule

// File: rtl/onewire_slave_if.sv
module onewire_slave_if #(
  parameter int TICKS_PER_US = 100,
  parameter int BYTE_W       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int RESET_US     = 480,
  parameter int SAMPLE_US    = 30,
  parameter int PD_WAIT_US   = 30,
  parameter int PD_LOW_US    = 120
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dq_i,
  output logic              dq_pull_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              bus_reset_o
);
  localparam int SLOT_PT_T  = SAMPLE_US * TICKS_PER_US;
  localparam int RESET_T    = RESET_US * TICKS_PER_US;
  localparam int PD_WAIT_T  = PD_WAIT_US * TICKS_PER_US;
  localparam int PD_LOW_T   = PD_LOW_US * TICKS_PER_US;
  localparam int PULL_MAX_T = (SLOT_PT_T > PD_LOW_T) ? SLOT_PT_T : PD_LOW_T;

  logic line_s, fell_s;
  logic bit_evt, bit_val, slot_rd, abort_s;
  logic tx_active, tx_bit;

  ow_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .dq_i(dq_i), .line_o(line_s), .fell_o(fell_s)
  );

  ow_slot_engine #(
    .SLOT_PT(SLOT_PT_T), .RESET_T(RESET_T),
    .PD_WAIT_T(PD_WAIT_T), .PD_LOW_T(PD_LOW_T)
  ) engine_i (
    .clk(clk), .rst(rst), .line_i(line_s), .fell_i(fell_s),
    .tx_active_i(tx_active), .tx_bit_i(tx_bit),
    .pull_o(dq_pull_o), .bit_evt_o(bit_evt), .bit_val_o(bit_val),
    .slot_rd_o(slot_rd), .abort_o(abort_s), .bus_reset_o(bus_reset_o)
  );

  ow_byte_shifter #(.DATA_W(BYTE_W)) shift_i (
    .clk(clk), .rst(rst), .bit_evt_i(bit_evt), .bit_val_i(bit_val),
    .slot_rd_i(slot_rd), .abort_i(abort_s),
    .tx_byte_i(tx_byte_i), .tx_valid_i(tx_valid_i),
    .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o),
    .tx_active_o(tx_active), .tx_bit_o(tx_bit)
  );

  assign tx_ready_o = ~tx_active;
endmodule

// File: rtl/ow_slave_chk.sv
module ow_slave_chk #(
  parameter int PULL_MAX = 12000
) (
  input logic clk,
  input logic rst,
  input logic pull,
  input logic rx_valid,
  input logic bus_reset,
  input logic tx_ready
);
  int pull_run;

  always_ff @(posedge clk) begin
    if (rst)       pull_run <= 0;
    else if (pull) pull_run <= pull_run + 1;
    else           pull_run <= 0;
  end

  assert_pull_run_R8: assert property (@(posedge clk) disable iff (rst)
    pull |-> (pull_run < PULL_MAX));

  assert_rxv_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_brst_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> !bus_reset);

  assert_brst_no_pull_R2: assert property (@(posedge clk) disable iff (rst)
    bus_reset |-> !pull);

  assert_brst_clears_tx_R6: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> tx_ready);
endmodule

bind onewire_slave_if ow_slave_chk #(.PULL_MAX(PULL_MAX_T)) chk_i (
  .clk(clk), .rst(rst), .pull(dq_pull_o), .rx_valid(rx_valid_o),
  .bus_reset(bus_reset_o), .tx_ready(tx_ready_o)
);

// File: tb/onewire_slave_if_tb_top.sv
module onewire_slave_if_tb_top;
  localparam int TK = 2;
  localparam int S  = 30 * TK;
  localparam int R  = 480 * TK;
  localparam int W  = 30 * TK;
  localparam int P  = 120 * TK;
  localparam int RST_LOW = 500 * TK;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, dq_m, dq_pull, rx_valid, tx_valid, tx_ready, bus_reset, dq_line;
  logic [7:0] rx_byte, tx_byte;
  assign dq_line = dq_m & ~dq_pull;

  onewire_slave_if #(.TICKS_PER_US(TK)) dut_i (
    .clk(clk), .rst(rst), .dq_i(dq_line), .dq_pull_o(dq_pull),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid),
    .tx_byte_i(tx_byte), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .bus_reset_o(bus_reset)
  );

  int cyc = 0, compared = 0, mismatched = 0;
  bit done = 0;
  bit    exp_pull[int];
  string pull_tag[int];
  int    exp_rxv[int];
  bit    exp_brst[int];
  int    rx_cnt = 0;
  logic [7:0] rx_acc = 8'h00;
  logic [7:0] last_rx = 8'h00;
  bit    tx_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, bit ok, int act, int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // per-cycle comparison against the behavioural expectation tables
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit ep, ev, eb;
      ep = exp_pull.exists(cyc);
      chk(ep ? pull_tag[cyc] : "R8 pull idle", dq_pull == ep, dq_pull, ep);
      ev = exp_rxv.exists(cyc);
      chk("R4 rx_valid", rx_valid == ev, rx_valid, ev);
      if (ev && rx_valid) begin
        chk("R4 rx_byte", rx_byte == exp_rxv[cyc][7:0], rx_byte, exp_rxv[cyc]);
        last_rx = rx_byte;
      end
      eb = exp_brst.exists(cyc);
      chk("R2 bus_reset", bus_reset == eb, bus_reset, eb);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_rx(bit b, int ev_edge);
    rx_acc[rx_cnt] = b;
    rx_cnt++;
    if (rx_cnt == 8) begin
      exp_rxv[ev_edge + 1] = int'(rx_acc);
      rx_cnt = 0;
      rx_acc = 8'h00;
    end
  endtask

  task automatic wslot(int low, bit b, int total);
    int n, r, e;
    n = cyc + 1;
    dq_m = 1'b0;
    idle(low);
    dq_m = 1'b1;
    r = n + low;
    e = (r + 2 > n + 3 + S) ? r + 2 : n + 3 + S;
    model_rx(b, e);
    idle(total - low);
  endtask

  task automatic wbyte(logic [7:0] v);
    for (int i = 0; i < 8; i++) wslot(v[i] ? 6 : 140, v[i], 150);
  endtask

  task automatic rslot();
    int n;
    bit b;
    b = tx_q.pop_front();
    n = cyc + 1;
    dq_m = 1'b0;
    if (!b) for (int m = n + 2; m <= n + 1 + S; m++) begin
      exp_pull[m] = 1'b1;
      pull_tag[m] = "R5 read-0 pull";
    end
    idle(4);
    dq_m = 1'b1;
    idle(22);
    chk("R5 read bit", dq_line == b, dq_line, b);
    idle(124);
  endtask

  task automatic breset();
    int n;
    n = cyc + 1;
    dq_m = 1'b0;
    if (tx_q.size() > 0 && !tx_q[0]) for (int m = n + 2; m <= n + 1 + S; m++) begin
      exp_pull[m] = 1'b1;
      pull_tag[m] = "R6 read-0 before reset";
    end
    exp_brst[n + 2 + R] = 1'b1;
    idle(RST_LOW);
    dq_m = 1'b1;
    for (int m = n + RST_LOW + 2 + W; m <= n + RST_LOW + 1 + W + P; m++) begin
      exp_pull[m] = 1'b1;
      pull_tag[m] = "R3 presence";
    end
    rx_cnt = 0;
    rx_acc = 8'h00;
    tx_q.delete();
    idle(W + 22);
    chk("R3 presence seen", dq_line == 1'b0, dq_line, 0);
    idle(P + 40);
  endtask

  task automatic txload(logic [7:0] v);
    tx_byte  = v;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R5 ready low after load", tx_ready == 1'b0, tx_ready, 0);
    for (int i = 0; i < 8; i++) tx_q.push_back(v[i]);
  endtask

  initial begin
    rst = 1'b1; dq_m = 1'b1; tx_valid = 1'b0; tx_byte = 8'h00;
    idle(5);
    chk("R1 pull in reset", dq_pull == 1'b0, dq_pull, 0);
    chk("R1 ready in reset", tx_ready == 1'b1, tx_ready, 1);
    rst = 1'b0;
    idle(1);
    chk("R1 pull", dq_pull == 1'b0, dq_pull, 0);
    chk("R1 rx_valid", rx_valid == 1'b0, rx_valid, 0);
    chk("R1 bus_reset", bus_reset == 1'b0, bus_reset, 0);
    chk("R1 tx_ready", tx_ready == 1'b1, tx_ready, 1);
    idle(20);

    breset();
    wbyte(8'hA5);
    chk("R4 byte A5", last_rx == 8'hA5, last_rx, 8'hA5);
    wbyte(8'h3C);
    chk("R4 byte 3C", last_rx == 8'h3C, last_rx, 8'h3C);

    txload(8'h96);
    for (int i = 0; i < 8; i++) begin
      rslot();
      chk("R5 tx_ready after read slot", tx_ready == (i == 7), tx_ready, (i == 7));
    end

    // R6: partial receive discarded by reset
    wslot(6, 1'b1, 150);
    wslot(140, 1'b0, 150);
    wslot(6, 1'b1, 150);
    breset();
    wbyte(8'h5A);
    chk("R6 byte after abort", last_rx == 8'h5A, last_rx, 8'h5A);

    // R6: held transmit byte dropped by reset
    txload(8'h0F);
    rslot();
    rslot();
    breset();
    chk("R6 tx_ready after reset", tx_ready == 1'b1, tx_ready, 1);
    wbyte(8'hC3);
    chk("R6 write decode after drop", last_rx == 8'hC3, last_rx, 8'hC3);

    // R7: long low below the threshold is one 0 bit
    for (int i = 0; i < 7; i++) wslot(6, 1'b1, 150);
    wslot(400 * TK, 1'b0, 410 * TK);
    chk("R7 long low is bit 0", last_rx == 8'h7F, last_rx, 8'h7F);

    wbyte(8'hFF);
    chk("R4 byte FF", last_rx == 8'hFF, last_rx, 8'hFF);
    wbyte(8'h00);
    chk("R4 byte 00", last_rx == 8'h00, last_rx, 8'h00);

    idle(50);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule